// File: doc/BRIEF.md
# Asynchronous SRAM Module Controller

This block runs a single read or write against an external asynchronous static RAM module built from four byte-wide banks. The banks share one memory address bus and one active-low output enable. Each bank has its own active-low chip select and write enable. A host raises a one-cycle request with a direction flag, an address, write data and a width mode. The controller then plays out the strobe sequence for that access and signals completion with a single-cycle done pulse.

The width mode is chosen per access. In 32-bit mode every lane takes part. In 16-bit mode one pair of lanes is used, chosen by the lowest host address bit. In 8-bit mode one lane is used, chosen by the two lowest host address bits. Write data is copied onto every lane. Read data comes back right-justified.

All timing windows are counted in clock cycles and set by parameters: how long the read strobes are held, the width of the write pulse, and the idle gap between a read and a following write. The memory data bus is modelled as separate in and out vectors plus a drive enable. The pad cell that joins them sits outside this block.

Top module: `sram_mod_ctrl`

## Requirements
- R1: While reset is asserted, every chip select, every write enable and the output enable are high (inactive). The data drive enable and done are low, and the read data output is zero.
- R2: `mode_i` selects the width. 0 and 3 both mean 32 bits: all four lanes, with memory address = host address bits 18:0. 1 means 16 bits: lanes 0-1 when host address bit 0 is 0 and lanes 2-3 when it is 1, with memory address = host address bits 19:1. 2 means 8 bits: the lane is numbered by host address bits 1:0, with memory address = host address bits 20:2. Exactly three chip selects are never low at once.
- R3: A read accepted on a clock edge holds the selected chip selects and the output enable low, with all write enables high, for RD_CYC cycles (2 by default) starting the next cycle. The data bus is sampled on the last edge of that window.
- R4: Read data is right-justified and zero-filled. In 32-bit mode lane 0 is the lowest byte. In 16-bit mode the low byte comes from the lower lane of the pair. In 8-bit mode the selected lane's byte is returned.
- R5: A write holds the selected chip selects and write enables low for WR_CYC cycles (2 by default), with the output enable high. Data lane k carries host write data byte k in 32-bit mode, byte k mod 2 in 16-bit mode, and byte 0 in 8-bit mode.
- R6: The data drive enable is high from the first cycle of the write strobe until one cycle after the write enables return high, and low at all other times.
- R7: A write accepted while the previous accepted access was a read begins its strobe only after TURN_CYC idle cycles (1 by default).
- R8: Done is high for exactly one cycle. For a read, that is the cycle right after the strobes are released. For a write, it is the cycle after the drive-hold cycle.
- R9: A request raised while an access is in progress is ignored: no strobe, memory content or completion results from it.
- R10: The read data output changes only on the edge that starts a read's done cycle.
- R11: A write enable is never low on a lane whose chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, taken only when idle |
| write_i | input | 1 | 1 = write, 0 = read |
| mode_i | input | 2 | Width mode (see R2) |
| addr_i | input | 21 | Host address; its low bits pick lanes in narrow modes |
| wdata_i | input | 32 | Host write data, right-justified |
| rdata_o | output | 32 | Read data, right-justified |
| done_o | output | 1 | One-cycle completion pulse |
| mem_addr_o | output | 19 | Memory address bus |
| mem_cs_n_o | output | 4 | Per-lane chip select, active low |
| mem_we_n_o | output | 4 | Per-lane write enable, active low |
| mem_oe_n_o | output | 1 | Shared output enable, active low |
| mem_dq_o | output | 32 | Data driven toward the memory |
| mem_dq_oe_o | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | 32 | Data returned by the memory |

## Verification
The properties assume that reset is low across at least the first clock edge. They also assume WR_CYC is at least 1 and that the module has four lanes, so that a group of three lanes can never be a legal selection. The stimulus asserts a request for a single cycle and then waits until the reference model reports idle. The one exception is a deliberate overlap case, where a second request is held during a running read to show that it is ignored. The memory model in the bench answers with a fixed garbage word whenever the output enable is high. A read sampled outside its window therefore shows up as wrong data.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    // Width modes; code 3 is an alias of full width.
    typedef enum logic [1:0] {
        WM_32  = 2'd0,
        WM_16  = 2'd1,
        WM_8   = 2'd2,
        WM_32B = 2'd3
    } width_mode_e;

    typedef enum logic [2:0] {
        SQ_IDLE  = 3'd0,
        SQ_TURN  = 3'd1,
        SQ_READ  = 3'd2,
        SQ_WRITE = 3'd3,
        SQ_REC   = 3'd4
    } seq_state_e;

endpackage

// File: rtl/sram_lane_map.sv
module sram_lane_map
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int SEL_W  = $clog2(LANES),
    localparam int HA_W   = ADDR_W + SEL_W,
    localparam int DATA_W = LANES * LANE_W
) (
    input  width_mode_e        mode_i,
    input  logic [HA_W-1:0]    host_addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [ADDR_W-1:0]  mem_addr_o,
    output logic [LANES-1:0]   lane_sel_o,
    output logic [DATA_W-1:0]  lane_wdata_o
);

    localparam int HALF = LANES / 2;

    // Memory word address: host address shifted by the lane-select bits in use (R2)
    always_comb begin
        case (mode_i)
            WM_16:   mem_addr_o = host_addr_i[ADDR_W:1];
            WM_8:    mem_addr_o = host_addr_i[HA_W-1:SEL_W];
            default: mem_addr_o = host_addr_i[ADDR_W-1:0];
        endcase
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam logic UPPER = (l >= HALF);
        logic                sel_l;
        logic [LANE_W-1:0]   dat_l;

        always_comb begin
            case (mode_i)
                WM_16: begin
                    sel_l = (UPPER == host_addr_i[0]);
                    dat_l = wdata_i[(l % HALF)*LANE_W +: LANE_W];
                end
                WM_8: begin
                    sel_l = (host_addr_i[SEL_W-1:0] == SEL_W'(l));
                    dat_l = wdata_i[LANE_W-1:0];
                end
                default: begin
                    sel_l = 1'b1;
                    dat_l = wdata_i[l*LANE_W +: LANE_W];
                end
            endcase
        end

        assign lane_sel_o[l]                    = sel_l;
        assign lane_wdata_o[l*LANE_W +: LANE_W] = dat_l;
    end

endmodule

// File: rtl/sram_rd_align.sv
module sram_rd_align
    import sram_ctl_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int SEL_W  = $clog2(LANES),
    localparam int DATA_W = LANES * LANE_W
) (
    input  width_mode_e        mode_i,
    input  logic [SEL_W-1:0]   sel_i,
    input  logic [DATA_W-1:0]  dq_i,
    output logic [DATA_W-1:0]  data_o
);

    localparam int HALF_W = DATA_W / 2;

    // Right-justify the active lane group, zero above it (R4)
    always_comb begin
        data_o = '0;
        case (mode_i)
            WM_16: data_o[HALF_W-1:0] = sel_i[0] ? dq_i[DATA_W-1:HALF_W]
                                                 : dq_i[HALF_W-1:0];
            WM_8:  data_o[LANE_W-1:0] = dq_i[int'(sel_i)*LANE_W +: LANE_W];
            default: data_o = dq_i;
        endcase
    end

endmodule

// File: rtl/sram_seq.sv
module sram_seq
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W   = 19,
    parameter int LANES    = 4,
    parameter int LANE_W   = 8,
    parameter int RD_CYC   = 2,
    parameter int WR_CYC   = 2,
    parameter int TURN_CYC = 1,
    localparam int SEL_W  = $clog2(LANES),
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               req_i,
    input  logic               write_i,
    input  width_mode_e        mode_i,
    input  logic [SEL_W-1:0]   sel_i,
    input  logic [ADDR_W-1:0]  maddr_i,
    input  logic [LANES-1:0]   lane_sel_i,
    input  logic [DATA_W-1:0]  lane_wdata_i,
    input  logic [DATA_W-1:0]  rd_aligned_i,
    output width_mode_e        cur_mode_o,
    output logic [SEL_W-1:0]   cur_sel_o,
    output logic [ADDR_W-1:0]  mem_addr_o,
    output logic [LANES-1:0]   mem_cs_n_o,
    output logic [LANES-1:0]   mem_we_n_o,
    output logic               mem_oe_n_o,
    output logic [DATA_W-1:0]  mem_dq_o,
    output logic               mem_dq_oe_o,
    output logic               done_o,
    output logic [DATA_W-1:0]  rdata_o
);

    localparam int MAX_RW = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
    localparam int MAX_C  = (MAX_RW > TURN_CYC) ? MAX_RW : TURN_CYC;
    localparam int CNT_W  = $clog2(MAX_C + 1);

    typedef struct packed {
        seq_state_e          state;
        logic [CNT_W-1:0]    cnt;
        logic                rd_recent;
        width_mode_e         mode;
        logic [SEL_W-1:0]    sel;
        logic [ADDR_W-1:0]   addr;
        logic [LANES-1:0]    lanes;
        logic [DATA_W-1:0]   wdat;
        logic [LANES-1:0]    cs_n;
        logic [LANES-1:0]    we_n;
        logic                oe_n;
        logic                dq_oe;
        logic                done;
        logic [DATA_W-1:0]   rdata;
    } seq_regs_t;

    localparam seq_regs_t RST_VAL = '{
        state:     SQ_IDLE,
        cnt:       '0,
        rd_recent: 1'b0,
        mode:      WM_32,
        sel:       '0,
        addr:      '0,
        lanes:     '0,
        wdat:      '0,
        cs_n:      '1,
        we_n:      '1,
        oe_n:      1'b1,
        dq_oe:     1'b0,
        done:      1'b0,
        rdata:     '0
    };

    seq_regs_t          seq_d, seq_q;
    logic               wr_go;
    logic [LANES-1:0]   wr_mask;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        wr_go      = 1'b0;
        wr_mask    = seq_q.lanes;

        case (seq_q.state)
            SQ_IDLE: begin
                // Requests are only looked at here (R9)
                if (req_i) begin
                    seq_d.mode  = mode_i;
                    seq_d.sel   = sel_i;
                    seq_d.addr  = maddr_i;
                    seq_d.lanes = lane_sel_i;
                    seq_d.wdat  = lane_wdata_i;
                    if (!write_i) begin
                        seq_d.state     = SQ_READ;
                        seq_d.cnt       = CNT_W'(RD_CYC - 1);
                        seq_d.cs_n      = ~lane_sel_i;
                        seq_d.oe_n      = 1'b0;
                        seq_d.rd_recent = 1'b1;
                    end else if (seq_q.rd_recent) begin
                        // Bus turnaround after a read (R7)
                        seq_d.state     = SQ_TURN;
                        seq_d.cnt       = CNT_W'(TURN_CYC - 1);
                        seq_d.rd_recent = 1'b0;
                    end else begin
                        wr_go   = 1'b1;
                        wr_mask = lane_sel_i;
                    end
                end
            end
            SQ_TURN: begin
                if (seq_q.cnt == '0) begin
                    wr_go = 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            SQ_READ: begin
                if (seq_q.cnt == '0) begin
                    // Sample on the last edge of the window (R3)
                    seq_d.rdata = rd_aligned_i;
                    seq_d.cs_n  = '1;
                    seq_d.oe_n  = 1'b1;
                    seq_d.state = SQ_IDLE;
                    seq_d.done  = 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            SQ_WRITE: begin
                if (seq_q.cnt == '0) begin
                    seq_d.cs_n  = '1;
                    seq_d.we_n  = '1;
                    seq_d.state = SQ_REC;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            SQ_REC: begin
                // Drivers held one cycle past the strobe (R6)
                seq_d.dq_oe = 1'b0;
                seq_d.done  = 1'b1;
                seq_d.state = SQ_IDLE;
            end
            default: begin
                seq_d = RST_VAL;
            end
        endcase

        if (wr_go) begin
            seq_d.state = SQ_WRITE;
            seq_d.cnt   = CNT_W'(WR_CYC - 1);
            seq_d.cs_n  = ~wr_mask;
            seq_d.we_n  = ~wr_mask;
            seq_d.dq_oe = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q <= RST_VAL;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign cur_mode_o  = seq_q.mode;
    assign cur_sel_o   = seq_q.sel;
    assign mem_addr_o  = seq_q.addr;
    assign mem_cs_n_o  = seq_q.cs_n;
    assign mem_we_n_o  = seq_q.we_n;
    assign mem_oe_n_o  = seq_q.oe_n;
    assign mem_dq_o    = seq_q.wdat;
    assign mem_dq_oe_o = seq_q.dq_oe;
    assign done_o      = seq_q.done;
    assign rdata_o     = seq_q.rdata;

endmodule

// File: rtl/sram_mod_ctrl.sv
module sram_mod_ctrl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W   = 19,
    parameter int LANES    = 4,
    parameter int LANE_W   = 8,
    parameter int RD_CYC   = 2,
    parameter int WR_CYC   = 2,
    parameter int TURN_CYC = 1,
    localparam int SEL_W  = $clog2(LANES),
    localparam int HA_W   = ADDR_W + SEL_W,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               req_i,
    input  logic               write_i,
    input  logic [1:0]         mode_i,
    input  logic [HA_W-1:0]    addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [DATA_W-1:0]  rdata_o,
    output logic               done_o,
    output logic [ADDR_W-1:0]  mem_addr_o,
    output logic [LANES-1:0]   mem_cs_n_o,
    output logic [LANES-1:0]   mem_we_n_o,
    output logic               mem_oe_n_o,
    output logic [DATA_W-1:0]  mem_dq_o,
    output logic               mem_dq_oe_o,
    input  logic [DATA_W-1:0]  mem_dq_i
);

    width_mode_e         mode_in;
    logic [ADDR_W-1:0]   map_addr;
    logic [LANES-1:0]    map_sel;
    logic [DATA_W-1:0]   map_wdata;
    width_mode_e         cur_mode;
    logic [SEL_W-1:0]    cur_sel;
    logic [DATA_W-1:0]   rd_aligned;

    assign mode_in = width_mode_e'(mode_i);

    sram_lane_map #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_map (
        .mode_i       (mode_in),
        .host_addr_i  (addr_i),
        .wdata_i      (wdata_i),
        .mem_addr_o   (map_addr),
        .lane_sel_o   (map_sel),
        .lane_wdata_o (map_wdata)
    );

    sram_rd_align #(
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_align (
        .mode_i (cur_mode),
        .sel_i  (cur_sel),
        .dq_i   (mem_dq_i),
        .data_o (rd_aligned)
    );

    sram_seq #(
        .ADDR_W   (ADDR_W),
        .LANES    (LANES),
        .LANE_W   (LANE_W),
        .RD_CYC   (RD_CYC),
        .WR_CYC   (WR_CYC),
        .TURN_CYC (TURN_CYC)
    ) u_seq (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .req_i        (req_i),
        .write_i      (write_i),
        .mode_i       (mode_in),
        .sel_i        (addr_i[SEL_W-1:0]),
        .maddr_i      (map_addr),
        .lane_sel_i   (map_sel),
        .lane_wdata_i (map_wdata),
        .rd_aligned_i (rd_aligned),
        .cur_mode_o   (cur_mode),
        .cur_sel_o    (cur_sel),
        .mem_addr_o   (mem_addr_o),
        .mem_cs_n_o   (mem_cs_n_o),
        .mem_we_n_o   (mem_we_n_o),
        .mem_oe_n_o   (mem_oe_n_o),
        .mem_dq_o     (mem_dq_o),
        .mem_dq_oe_o  (mem_dq_oe_o),
        .done_o       (done_o),
        .rdata_o      (rdata_o)
    );

endmodule

// File: rtl/sram_mod_ctrl_chk.sv
module sram_mod_ctrl_chk #(
    parameter int LANES  = 4,
    parameter int WR_CYC = 2,
    parameter int DATA_W = 32
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               done_o,
    input logic [DATA_W-1:0]  rdata_o,
    input logic [LANES-1:0]   cs_n,
    input logic [LANES-1:0]   we_n,
    input logic               oe_n,
    input logic               dq_oe
);

    logic [15:0] we_run_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            we_run_q <= '0;
        end else if (!(&we_n)) begin
            we_run_q <= we_run_q + 16'd1;
        end else begin
            we_run_q <= '0;
        end
    end

    AST_WE_NEEDS_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((~we_n) & cs_n) == '0);                                   // R11
    AST_NO_THREE_LANES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(~cs_n) != 3);                                   // R2
    AST_OE_OFF_IN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(&we_n) |-> oe_n);                                        // R5
    AST_WE_PULSE_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((&we_n) && we_run_q != '0) |-> (we_run_q >= 16'(WR_CYC))); // R5
    AST_NO_DRIVE_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dq_oe |-> oe_n);                                           // R6
    AST_DRIVE_AT_WE_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(&we_n) |-> dq_oe);                                   // R6
    AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);                                       // R8
    AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> $stable(rdata_o));                             // R10

endmodule

bind sram_mod_ctrl sram_mod_ctrl_chk #(
    .LANES  (LANES),
    .WR_CYC (WR_CYC),
    .DATA_W (DATA_W)
) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .done_o  (done_o),
    .rdata_o (rdata_o),
    .cs_n    (mem_cs_n_o),
    .we_n    (mem_we_n_o),
    .oe_n    (mem_oe_n_o),
    .dq_oe   (mem_dq_oe_o)
);

// File: tb/sram_mod_ctrl_tb_top.sv
module sram_mod_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int RD_N   = 2;
    localparam int WR_N   = 2;
    localparam int TURN_N = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        write = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [20:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        done;
    logic [18:0] mem_addr;
    logic [3:0]  cs_n, we_n;
    logic        oe_n;
    logic [31:0] dq_o;
    logic        dq_oe;
    logic [31:0] dq_i;

    int n_tests = 0;
    int n_fail  = 0;
    bit running = 1'b0;
    bit last_rd = 1'b0;
    logic [31:0] exp_rdata = '0;

    logic [7:0] pmem [16][4];   // pin-level memory
    logic [7:0] shad [16][4];   // host-view shadow

    typedef struct {
        logic [3:0]  cs_n;
        logic [3:0]  we_n;
        logic        oe_n;
        logic        dq_oe;
        logic        done;
        logic        chk_a;
        logic [18:0] a;
        logic        chk_d;
        logic [31:0] d;
        logic        rd_done;
        logic [31:0] rv;
        string       tag;
    } snap_t;

    snap_t exp_q[$];
    snap_t cur_s;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_mod_ctrl dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .req_i       (req),
        .write_i     (write),
        .mode_i      (mode),
        .addr_i      (addr),
        .wdata_i     (wdata),
        .rdata_o     (rdata),
        .done_o      (done),
        .mem_addr_o  (mem_addr),
        .mem_cs_n_o  (cs_n),
        .mem_we_n_o  (we_n),
        .mem_oe_n_o  (oe_n),
        .mem_dq_o    (dq_o),
        .mem_dq_oe_o (dq_oe),
        .mem_dq_i    (dq_i)
    );

    // Memory answers garbage unless its output enable is low
    assign dq_i = oe_n ? 32'hDEAD_BEEF
                       : {pmem[mem_addr[3:0]][3], pmem[mem_addr[3:0]][2],
                          pmem[mem_addr[3:0]][1], pmem[mem_addr[3:0]][0]};

    always @(posedge clk) begin
        for (int l = 0; l < 4; l++) begin
            if (!cs_n[l] && !we_n[l]) pmem[mem_addr[3:0]][l] <= dq_o[8*l +: 8];
        end
    end

    task automatic chk(input string r, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", r, what, act, exp);
        end
    endtask

    function automatic snap_t idle_snap(input string t);
        snap_t s;
        s.cs_n = 4'hF; s.we_n = 4'hF; s.oe_n = 1'b1; s.dq_oe = 1'b0;
        s.done = 1'b0; s.chk_a = 1'b0; s.a = '0; s.chk_d = 1'b0; s.d = '0;
        s.rd_done = 1'b0; s.rv = '0; s.tag = t;
        return s;
    endfunction

    function automatic int eff_mode(input logic [1:0] m);
        return (m == 2'd3) ? 0 : int'(m);
    endfunction

    function automatic logic [3:0] lane_mask(input int m, input logic [20:0] a);
        if (m == 1) return a[0] ? 4'hC : 4'h3;
        if (m == 2) return 4'b0001 << a[1:0];
        return 4'hF;
    endfunction

    function automatic logic [18:0] word_addr(input int m, input logic [20:0] a);
        if (m == 1) return a[19:1];
        if (m == 2) return a[20:2];
        return a[18:0];
    endfunction

    function automatic logic [31:0] rd_expect(input int m, input logic [20:0] a);
        logic [3:0] ix;
        ix = word_addr(m, a) & 19'hF;
        if (m == 1) begin
            if (a[0]) return {16'h0, shad[ix][3], shad[ix][2]};
            return {16'h0, shad[ix][1], shad[ix][0]};
        end
        if (m == 2) return {24'h0, shad[ix][a[1:0]]};
        return {shad[ix][3], shad[ix][2], shad[ix][1], shad[ix][0]};
    endfunction

    function automatic logic [31:0] lane_data(input int m, input logic [31:0] w);
        if (m == 1) return {w[15:0], w[15:0]};
        if (m == 2) return {4{w[7:0]}};
        return w;
    endfunction

    // Reference model: on each accepted request, queue the expected
    // per-cycle view of the memory pins for the whole access.
    always @(posedge clk) begin
        if (rst_n && req && exp_q.size() == 0) begin
            int          m;
            logic [3:0]  mk;
            logic [18:0] wa;
            logic [31:0] ld;
            snap_t       s;
            m  = eff_mode(mode);
            mk = lane_mask(m, addr);
            wa = word_addr(m, addr);
            ld = lane_data(m, wdata);
            if (!write) begin
                for (int k = 0; k < RD_N; k++) begin
                    s = idle_snap("R3");
                    s.cs_n = ~mk; s.oe_n = 1'b0; s.chk_a = 1'b1; s.a = wa;
                    exp_q.push_back(s);
                end
                s = idle_snap("R8");
                s.done = 1'b1; s.rd_done = 1'b1; s.rv = rd_expect(m, addr);
                exp_q.push_back(s);
                last_rd = 1'b1;
            end else begin
                if (last_rd) begin
                    for (int k = 0; k < TURN_N; k++) exp_q.push_back(idle_snap("R7"));
                end
                last_rd = 1'b0;
                for (int l = 0; l < 4; l++) begin
                    if (mk[l]) shad[wa[3:0]][l] = ld[8*l +: 8];
                end
                for (int k = 0; k < WR_N; k++) begin
                    s = idle_snap("R5");
                    s.cs_n = ~mk; s.we_n = ~mk; s.dq_oe = 1'b1;
                    s.chk_a = 1'b1; s.a = wa; s.chk_d = 1'b1; s.d = ld;
                    exp_q.push_back(s);
                end
                s = idle_snap("R6");
                s.dq_oe = 1'b1; s.chk_a = 1'b1; s.a = wa; s.chk_d = 1'b1; s.d = ld;
                exp_q.push_back(s);
                s = idle_snap("R8");
                s.done = 1'b1;
                exp_q.push_back(s);
            end
        end
    end

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (running) begin
            if (exp_q.size() != 0) cur_s = exp_q.pop_front();
            else                   cur_s = idle_snap("R9");
            if (cur_s.rd_done) exp_rdata = cur_s.rv;
            chk(cur_s.tag, "cs_n (R2 lanes)", {28'h0, cs_n}, {28'h0, cur_s.cs_n});
            chk(cur_s.tag, "we_n", {28'h0, we_n}, {28'h0, cur_s.we_n});
            chk(cur_s.tag, "oe_n", {31'h0, oe_n}, {31'h0, cur_s.oe_n});
            chk("R6", "dq_oe", {31'h0, dq_oe}, {31'h0, cur_s.dq_oe});
            chk("R8", "done", {31'h0, done}, {31'h0, cur_s.done});
            if (cur_s.chk_a) chk("R2", "mem_addr", {13'h0, mem_addr}, {13'h0, cur_s.a});
            if (cur_s.chk_d) chk("R5", "dq_o", dq_o, cur_s.d);
            chk(cur_s.rd_done ? "R4" : "R10", "rdata", rdata, exp_rdata);
            chk("R11", "we without cs", {28'h0, (~we_n) & cs_n}, 32'h0);
        end
    end

    task automatic access(input logic wr, input logic [1:0] md,
                          input logic [20:0] a, input logic [31:0] d,
                          input bit intrude);
        req = 1'b1; write = wr; mode = md; addr = a; wdata = d;
        @(posedge clk); #2;
        if (intrude) begin
            // R9: write attempt while the access runs
            write = 1'b1; mode = 2'd0; addr = 21'd7; wdata = 32'hFFFF_FFFF;
            @(posedge clk); #2;
        end
        req = 1'b0;
        while (exp_q.size() != 0) begin
            @(posedge clk); #2;
        end
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            for (int l = 0; l < 4; l++) begin
                pmem[i][l] = 8'(i*16 + l + 1);
                shad[i][l] = 8'(i*16 + l + 1);
            end
        end
        repeat (2) @(negedge clk);
        // R1: reset state
        chk("R1", "cs_n", {28'h0, cs_n}, 32'hF);
        chk("R1", "we_n", {28'h0, we_n}, 32'hF);
        chk("R1", "oe_n", {31'h0, oe_n}, 32'h1);
        chk("R1", "dq_oe", {31'h0, dq_oe}, 32'h0);
        chk("R1", "done", {31'h0, done}, 32'h0);
        chk("R1", "rdata", rdata, 32'h0);
        @(posedge clk); #2;
        rst_n = 1'b1;
        running = 1'b1;

        access(1'b1, 2'd0, 21'd5, 32'hA1B2_C3D4, 1'b0);   // full-width write
        access(1'b0, 2'd0, 21'd5, 32'h0, 1'b0);           // full-width read
        access(1'b1, 2'd1, 21'd11, 32'h1234_BEEF, 1'b0);  // R7 turnaround, upper pair
        access(1'b0, 2'd1, 21'd10, 32'h0, 1'b0);          // lower half
        access(1'b0, 2'd1, 21'd11, 32'h0, 1'b0);          // upper half
        access(1'b0, 2'd0, 21'd5, 32'h0, 1'b0);
        access(1'b1, 2'd1, 21'd16, 32'h0000_6655, 1'b0);  // lower pair of word 8
        access(1'b0, 2'd0, 21'd8, 32'h0, 1'b0);
        access(1'b1, 2'd2, 21'd26, 32'hFFFF_FF5A, 1'b0);  // byte lane 2 of word 6
        access(1'b1, 2'd2, 21'd24, 32'h0000_0077, 1'b0);  // write after write
        for (int ln = 0; ln < 4; ln++) access(1'b0, 2'd2, 21'(24 + ln), 32'h0, 1'b0);
        access(1'b1, 2'd3, 21'd9, 32'hCAFE_F00D, 1'b0);   // alias mode
        access(1'b0, 2'd3, 21'd9, 32'h0, 1'b0);
        access(1'b0, 2'd0, 21'd9, 32'h0, 1'b0);
        access(1'b0, 2'd0, 21'd7, 32'h0, 1'b1);           // overlapping request
        access(1'b0, 2'd0, 21'd7, 32'h0, 1'b0);
        chk("R9", "word 7 untouched", rdata,
            {8'h74, 8'h73, 8'h72, 8'h71});

        repeat (3) @(posedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule